// File: doc/BRIEF.md
# CSR Access and Trap-Return Unit

This block executes the system-class instructions of a hart that has machine and supervisor modes. It performs the six read-modify-write operations on control and status registers (CSRs). It pops the interrupt-enable stack on a return from a machine or supervisor trap. It reports the exception that an environment call, a breakpoint, a trapped wait-for-interrupt or an illegal access produces. The block models three CSRs:

- a status register with writable bits SIE (1), MIE (3), SPIE (5), MPIE (7) and TW (21); every other bit reads as zero;
- a scratch register at address 0x340;
- a read-only hart identifier at address 0xF14.

The status register sits at address 0x300.

The pipeline presents one whole 32-bit instruction word, the value of the first source register and the current privilege level (U=0, S=1, M=3) with `in_valid`. The instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. CSR state changes at that same edge. One cycle later a single result record appears on the result port. The record holds the old CSR value, the destination index, the writeback and read-side-effect enables, and an exception flag with its cause.

The result port is valid/ready. A record stays on the port, unchanged, until it is taken on an edge where `res_valid` and `res_ready` are both high. `in_ready` is high whenever the result slot is empty or is being emptied in that cycle. The input stalls while a record waits, so a new instruction can be accepted in the same cycle that the previous record leaves.

Top module: `csr_trap_unit`

## Requirements
- R1: After reset the status and scratch registers are zero, `res_valid` is low and `in_ready` is high.
- R2: An instruction accepted at edge N gives its record at edge N+1. While `res_valid` is high and `res_ready` is low, `in_ready` is low and every result field holds steady. Records leave in the order the instructions were accepted.
- R3: The write forms are funct3 001 (operand is the register value) and funct3 101 (operand is the 5-bit rs1 field, zero-extended). The CSR takes the operand, and the record carries the previous CSR value.
- R4: The set forms (funct3 010 and 110) store old OR operand. The clear forms (funct3 011 and 111) store old AND NOT operand. Only the writable status bits ever change.
- R5: A set or clear form whose rs1 field is zero writes nothing, so it may read a read-only CSR without fault.
- R6: A write form with rd = 0 does not read. Its record has `res_rd_side` = 0 and `res_rdata` = 0, and the write still takes place. Every other legal CSR access has `res_rd_side` = 1. `res_rd_we` is 1 exactly for a legal CSR access with rd != 0.
- R7: MRET (function field 0x302) sets MIE to the previous MPIE and sets MPIE to 1. SRET (0x102) does the same to SIE and SPIE.
- R8: ECALL (0x000) raises cause 8, 9 or 11 for privilege U, S or M. EBREAK (0x001) raises cause 3. Neither changes any register.
- R9: WFI (0x105) raises illegal instruction (cause 2) when TW is 1 and the privilege is not M. Otherwise it has no effect.
- R10: Access to an address other than 0x300, 0x340 or 0xF14 raises cause 2. So does any write to an address whose top two bits are 11. Such an access changes no state, and its record has both enables low.
- R11: An opcode other than 1110011 raises cause 2. So does funct3 100, or funct3 000 with a nonzero rd or rs1 field or an unknown function field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_instr | input | 32 | Full instruction word |
| in_rs1_val | input | XLEN | Value of the first source register |
| in_priv | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| res_valid | output | 1 | Result record present |
| res_ready | input | 1 | Consumer takes the record this cycle |
| res_rd | output | 5 | Destination register index |
| res_rdata | output | XLEN | Old CSR value, zero when no read |
| res_rd_we | output | 1 | Write `res_rdata` to the register file |
| res_rd_side | output | 1 | The CSR was read (read side effects apply) |
| res_exc | output | 1 | Exception raised |
| res_cause | output | 5 | Exception cause code |
| status_o | output | XLEN | Current status register |

## Verification
Two things can fall in one cycle: a held record leaving the port, and the next instruction being accepted and updating CSR state. The bench provokes this by driving `res_ready` from a pseudo-random pattern while it sends back-to-back writes to the scratch register. Each write must return the value stored by the one before it, so any leak of the new state into the departing record, and any lost or duplicated record, shows up as a mismatch in the scoreboard. A separate run holds `res_ready` low after a single accepted instruction, and checks that the record stays on the port and that `in_ready` stays low until release.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;

  localparam int ILEN    = 32;
  localparam int CAUSE_W = 5;

  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  // privilege levels
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  // implemented addresses
  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_HARTID  = 12'hF14;

  // system function field values (funct3 == 000)
  localparam logic [11:0] F_ECALL  = 12'h000;
  localparam logic [11:0] F_EBREAK = 12'h001;
  localparam logic [11:0] F_SRET   = 12'h102;
  localparam logic [11:0] F_WFI    = 12'h105;
  localparam logic [11:0] F_MRET   = 12'h302;

  // status bit positions
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_TW   = 21;

  localparam logic [31:0] STATUS_WMASK =
    (32'd1 << ST_SIE) | (32'd1 << ST_MIE) | (32'd1 << ST_SPIE) |
    (32'd1 << ST_MPIE) | (32'd1 << ST_TW);

  // exception causes
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_BREAK   = 5'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_ECALL_U = 5'd8;

  typedef enum logic [2:0] {
    K_CSR, K_ECALL, K_EBREAK, K_MRET, K_SRET, K_WFI, K_BAD
  } kind_e;

  typedef enum logic [1:0] {
    OP_WR, OP_SET, OP_CLR
  } csrop_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_trap_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output kind_e           kind,
  output csrop_e          op,
  output logic            use_imm,
  output logic            rd_en,
  output logic            wr_en,
  output logic [4:0]      rd,
  output logic [4:0]      src,
  output logic [11:0]     addr
);

  logic [6:0] opcode;
  logic [2:0] funct3;

  assign opcode = instr[6:0];
  assign funct3 = instr[14:12];
  assign rd     = instr[11:7];
  assign src    = instr[19:15];
  assign addr   = instr[31:20];

  always_comb begin
    kind    = K_BAD;
    op      = OP_WR;
    use_imm = funct3[2];
    if (opcode == OPC_SYSTEM) begin
      if (funct3 == 3'b000) begin
        if (rd == 5'd0 && src == 5'd0) begin
          case (addr)
            F_ECALL:  kind = K_ECALL;
            F_EBREAK: kind = K_EBREAK;
            F_MRET:   kind = K_MRET;
            F_SRET:   kind = K_SRET;
            F_WFI:    kind = K_WFI;
            default:  kind = K_BAD;
          endcase
        end
      end else if (funct3 != 3'b100) begin
        kind = K_CSR;
        case (funct3[1:0])
          2'b01:   op = OP_WR;
          2'b10:   op = OP_SET;
          default: op = OP_CLR;
        endcase
      end
    end
  end

  // write forms skip the read for rd = x0; set/clear skip the write for a zero source field
  assign rd_en = (op != OP_WR) || (rd != 5'd0);
  assign wr_en = (op == OP_WR) || (src != 5'd0);

endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HART_ID = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  kind_e           kind,
  input  csrop_e          op,
  input  logic            wr_en,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] old_val,
  output logic            addr_ok,
  output logic            addr_ro,
  output logic [XLEN-1:0] status_q
);

  localparam logic [XLEN-1:0] WMASK = XLEN'(STATUS_WMASK);

  logic [XLEN-1:0] status_d;
  logic [XLEN-1:0] scratch_q, scratch_d;
  logic [XLEN-1:0] new_val;

  always_comb begin
    addr_ok = 1'b1;
    case (addr)
      A_STATUS:  old_val = status_q;
      A_SCRATCH: old_val = scratch_q;
      A_HARTID:  old_val = HART_ID;
      default: begin
        old_val = '0;
        addr_ok = 1'b0;
      end
    endcase
  end

  assign addr_ro = (addr[11:10] == 2'b11);

  always_comb begin
    case (op)
      OP_SET:  new_val = old_val | operand;
      OP_CLR:  new_val = old_val & ~operand;
      default: new_val = operand;
    endcase
  end

  always_comb begin
    status_d  = status_q;
    scratch_d = scratch_q;
    if (commit) begin
      case (kind)
        K_CSR: begin
          if (wr_en && addr == A_STATUS)  status_d  = new_val;
          if (wr_en && addr == A_SCRATCH) scratch_d = new_val;
        end
        K_MRET: begin
          status_d[ST_MIE]  = status_q[ST_MPIE];
          status_d[ST_MPIE] = 1'b1;
        end
        K_SRET: begin
          status_d[ST_SIE]  = status_q[ST_SPIE];
          status_d[ST_SPIE] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // one flop per writable status bit; the rest are tied to zero
  for (genvar i = 0; i < XLEN; i++) begin : g_stat
    if (WMASK[i]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= status_d[i];
      end
      assign status_q[i] = bit_q;
    end else begin : g_zero
      assign status_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) scratch_q <= '0;
    else        scratch_q <= scratch_d;
  end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import csr_trap_pkg::*;
(
  input  kind_e               kind,
  input  logic                wr_en,
  input  logic [1:0]          priv,
  input  logic                tw,
  input  logic                addr_ok,
  input  logic                addr_ro,
  output logic                exc,
  output logic [CAUSE_W-1:0]  cause
);

  always_comb begin
    exc   = 1'b0;
    cause = '0;
    case (kind)
      K_CSR: begin
        if (!addr_ok || (wr_en && addr_ro)) begin
          exc   = 1'b1;
          cause = CAUSE_ILLEGAL;
        end
      end
      K_ECALL: begin
        exc   = 1'b1;
        cause = CAUSE_ECALL_U + CAUSE_W'(priv);
      end
      K_EBREAK: begin
        exc   = 1'b1;
        cause = CAUSE_BREAK;
      end
      K_WFI: begin
        if (tw && priv != PRV_M) begin
          exc   = 1'b1;
          cause = CAUSE_ILLEGAL;
        end
      end
      K_MRET, K_SRET: ;
      default: begin
        exc   = 1'b1;
        cause = CAUSE_ILLEGAL;
      end
    endcase
  end

endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
  import csr_trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HART_ID = 32'h0000_0007
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ILEN-1:0]     in_instr,
  input  logic [XLEN-1:0]     in_rs1_val,
  input  logic [1:0]          in_priv,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [4:0]          res_rd,
  output logic [XLEN-1:0]     res_rdata,
  output logic                res_rd_we,
  output logic                res_rd_side,
  output logic                res_exc,
  output logic [CAUSE_W-1:0]  res_cause,
  output logic [XLEN-1:0]     status_o
);

  kind_e               kind;
  csrop_e              op;
  logic                use_imm, rd_en, wr_en;
  logic [4:0]          rd, src;
  logic [11:0]         addr;
  logic [XLEN-1:0]     operand, old_val;
  logic                addr_ok, addr_ro, exc;
  logic [CAUSE_W-1:0]  cause;
  logic                fire, commit, legal_csr;

  csr_decode u_dec (
    .instr(in_instr), .kind(kind), .op(op), .use_imm(use_imm),
    .rd_en(rd_en), .wr_en(wr_en), .rd(rd), .src(src), .addr(addr)
  );

  assign operand = use_imm ? XLEN'(src) : in_rs1_val;

  csr_regs #(.XLEN(XLEN), .HART_ID(HART_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .kind(kind), .op(op),
    .wr_en(wr_en), .addr(addr), .operand(operand), .old_val(old_val),
    .addr_ok(addr_ok), .addr_ro(addr_ro), .status_q(status_o)
  );

  trap_ctrl u_trap (
    .kind(kind), .wr_en(wr_en), .priv(in_priv), .tw(status_o[ST_TW]),
    .addr_ok(addr_ok), .addr_ro(addr_ro), .exc(exc), .cause(cause)
  );

  assign in_ready  = !res_valid || res_ready;
  assign fire      = in_valid && in_ready;
  assign commit    = fire && !exc;
  assign legal_csr = (kind == K_CSR) && !exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_rd      <= '0;
      res_rdata   <= '0;
      res_rd_we   <= 1'b0;
      res_rd_side <= 1'b0;
      res_exc     <= 1'b0;
      res_cause   <= '0;
    end else if (fire) begin
      res_valid   <= 1'b1;
      res_rd      <= rd;
      res_rdata   <= (legal_csr && rd_en) ? old_val : '0;
      res_rd_we   <= legal_csr && (rd != 5'd0);
      res_rd_side <= legal_csr && rd_en;
      res_exc     <= exc;
      res_cause   <= cause;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/csr_trap_chk.sv
module csr_trap_chk
  import csr_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [XLEN-1:0]    res_rdata,
  input logic               res_rd_we,
  input logic               res_rd_side,
  input logic               res_exc,
  input logic [CAUSE_W-1:0] res_cause,
  input logic [XLEN-1:0]    status_o
);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_rdata) &&
                                $stable(res_exc) && $stable(res_cause));

  // R10
  exc_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_exc |-> !res_rd_we && !res_rd_side);

  // R8
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_exc |-> (res_cause == 5'd2 || res_cause == 5'd3 ||
                              res_cause == 5'd8 || res_cause == 5'd9 ||
                              res_cause == 5'd10 || res_cause == 5'd11));

  // R2
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(status_o));

  // R6
  we_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_rd_we |-> res_rd_side);

endmodule

bind csr_trap_unit csr_trap_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_rdata(res_rdata),
  .res_rd_we(res_rd_we), .res_rd_side(res_rd_side), .res_exc(res_exc),
  .res_cause(res_cause), .status_o(status_o)
);

// File: tb/tb_csr_trap_unit.sv
`timescale 1ns/1ps
module tb_csr_trap_unit;

  localparam logic [31:0] HART = 32'h0000_0007;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rs1_val = '0;
  logic [1:0]  in_priv = 2'd3;
  logic        res_valid;
  logic        res_ready;
  logic [4:0]  res_rd;
  logic [31:0] res_rdata;
  logic        res_rd_we, res_rd_side, res_exc;
  logic [4:0]  res_cause;
  logic [31:0] status_o;

  always #2 clk = ~clk;

  csr_trap_unit #(.XLEN(32), .HART_ID(HART)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rs1_val(in_rs1_val), .in_priv(in_priv),
    .res_valid(res_valid), .res_ready(res_ready), .res_rd(res_rd),
    .res_rdata(res_rdata), .res_rd_we(res_rd_we), .res_rd_side(res_rd_side),
    .res_exc(res_exc), .res_cause(res_cause), .status_o(status_o)
  );

  typedef struct {
    logic [4:0]  rd;
    logic [31:0] rdata;
    logic        we, side, exc;
    logic [4:0]  cause;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          bp_mode = 0;   // 0 ready, 1 random, 2 stalled
  logic [31:0] m_status = '0;
  logic [31:0] m_scratch = '0;
  localparam logic [31:0] WM = 32'h0020_00AA;

  function automatic logic [31:0] csr_i(logic [2:0] f3, logic [4:0] rd,
                                        logic [4:0] s, logic [11:0] a);
    return {a, s, f3, rd, 7'b1110011};
  endfunction

  function automatic logic [31:0] sys_i(logic [11:0] f);
    return {f, 5'd0, 3'd0, 5'd0, 7'b1110011};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model built from the requirements; returns the expected record
  function automatic exp_t model(logic [31:0] ins, logic [31:0] v, logic [1:0] pr);
    exp_t e;
    logic [2:0]  f3 = ins[14:12];
    logic [4:0]  rd = ins[11:7];
    logic [4:0]  s  = ins[19:15];
    logic [11:0] a  = ins[31:20];
    logic wr, rden, known;
    logic [31:0] opnd, old, nv;
    e.rd = rd; e.rdata = 0; e.we = 0; e.side = 0; e.exc = 0; e.cause = 0;
    if (ins[6:0] != 7'b1110011 || f3 == 3'b100) begin
      e.exc = 1; e.cause = 2;
    end else if (f3 == 3'b000) begin
      if (rd != 0 || s != 0) begin e.exc = 1; e.cause = 2; end
      else case (a)
        12'h000: begin e.exc = 1; e.cause = 5'd8 + 5'(pr); end
        12'h001: begin e.exc = 1; e.cause = 3; end
        12'h302: begin m_status[3] = m_status[7]; m_status[7] = 1; end
        12'h102: begin m_status[1] = m_status[5]; m_status[5] = 1; end
        12'h105: if (m_status[21] && pr != 2'd3) begin e.exc = 1; e.cause = 2; end
        default: begin e.exc = 1; e.cause = 2; end
      endcase
    end else begin
      wr    = (f3[1:0] == 2'b01) || (s != 0);
      rden  = (f3[1:0] != 2'b01) || (rd != 0);
      opnd  = f3[2] ? {27'd0, s} : v;
      known = (a == 12'h300) || (a == 12'h340) || (a == 12'hF14);
      if (!known || (wr && a[11:10] == 2'b11)) begin
        e.exc = 1; e.cause = 2;
      end else begin
        old = (a == 12'h300) ? m_status : (a == 12'h340) ? m_scratch : HART;
        nv  = (f3[1:0] == 2'b01) ? opnd : (f3[1:0] == 2'b10) ? (old | opnd) : (old & ~opnd);
        if (wr && a == 12'h300) m_status  = nv & WM;
        if (wr && a == 12'h340) m_scratch = nv;
        e.rdata = rden ? old : 0;
        e.side  = rden;
        e.we    = (rd != 0);
      end
    end
    return e;
  endfunction

  task automatic send(logic [31:0] ins, logic [31:0] v, logic [1:0] pr, string tag);
    exp_t e;
    logic acc;
    e = model(ins, v, pr);
    e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    in_instr = ins; in_rs1_val = v; in_priv = pr; in_valid = 1'b1;
    forever begin
      acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_status(string tag);
    drain();
    chk(tag, status_o, m_status, "status");
  endtask

  // result-side ready generator
  initial begin
    logic [7:0] lf = 8'hA5;
    res_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      res_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? lf[0] : 1'b0;
    end
  end

  // monitor: compare each departing record with the scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid && !res_ready && bp_mode == 1)
      chk("R2", 32'(in_ready), 32'd0, "in_ready while stalled");
    if (rst_n && res_valid && res_ready) begin
      if (sbq.size() == 0) begin
        chk("R2", 32'd1, 32'd0, "unexpected record");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, res_rdata, e.rdata, "rdata");
        chk(e.tag, {res_rd, res_rd_we, res_rd_side, res_exc, res_cause},
                   {e.rd, e.we, e.side, e.exc, e.cause}, "rd/we/side/exc/cause");
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", 32'(res_valid), 0, "res_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", status_o, 0, "status after reset");
    chk("R1", 32'(in_ready), 1, "in_ready after reset");
    chk("R1", 32'(res_valid), 0, "res_valid after reset");

    // R3 write forms, register and immediate operand
    send(csr_i(3'b001, 5'd5, 5'd9, 12'h340), 32'hDEAD_BEEF, 2'd3, "R3");
    send(csr_i(3'b101, 5'd6, 5'd31, 12'h340), 32'hFFFF_FFFF, 2'd3, "R3");
    // R5 read without write
    send(csr_i(3'b010, 5'd7, 5'd0, 12'h340), 32'h1234_5678, 2'd3, "R5");
    // R4 set / clear on status and scratch
    send(csr_i(3'b010, 5'd1, 5'd3, 12'h300), 32'hFFFF_FFFF, 2'd3, "R4");
    check_status("R4");
    send(csr_i(3'b011, 5'd2, 5'd4, 12'h300), 32'h0000_0008, 2'd3, "R4");
    send(csr_i(3'b110, 5'd2, 5'd12, 12'h340), 32'h0, 2'd3, "R4");
    send(csr_i(3'b111, 5'd2, 5'd5, 12'h340), 32'h0, 2'd3, "R4");
    send(csr_i(3'b010, 5'd2, 5'd0, 12'h340), 32'h0, 2'd3, "R4");
    check_status("R4");
    // R6 write with rd = x0
    send(csr_i(3'b001, 5'd0, 5'd8, 12'h340), 32'h0000_1234, 2'd3, "R6");
    send(csr_i(3'b010, 5'd3, 5'd0, 12'h340), 32'h0, 2'd3, "R6");
    // R5 read-only id readable through set/clear with zero source
    send(csr_i(3'b010, 5'd4, 5'd0, 12'hF14), 32'h0, 2'd3, "R5");
    send(csr_i(3'b111, 5'd4, 5'd0, 12'hF14), 32'h0, 2'd3, "R5");
    // R10 illegal accesses leave state untouched
    send(csr_i(3'b001, 5'd4, 5'd1, 12'hF14), 32'h5, 2'd3, "R10");
    send(csr_i(3'b010, 5'd4, 5'd1, 12'h123), 32'h5, 2'd3, "R10");
    send(csr_i(3'b110, 5'd4, 5'd1, 12'hF14), 32'h0, 2'd3, "R10");
    send(csr_i(3'b001, 5'd4, 5'd1, 12'h7C0), 32'h5, 2'd3, "R10");
    send(csr_i(3'b010, 5'd4, 5'd0, 12'h340), 32'h0, 2'd3, "R10");
    check_status("R10");
    // R7 trap returns
    send(csr_i(3'b001, 5'd1, 5'd1, 12'h300), 32'h0000_0082, 2'd3, "R7");
    send(sys_i(12'h302), 32'h0, 2'd3, "R7");
    check_status("R7");
    send(sys_i(12'h102), 32'h0, 2'd1, "R7");
    check_status("R7");
    // R8 environment call and breakpoint
    send(sys_i(12'h000), 32'h0, 2'd0, "R8");
    send(sys_i(12'h000), 32'h0, 2'd1, "R8");
    send(sys_i(12'h000), 32'h0, 2'd3, "R8");
    send(sys_i(12'h001), 32'h0, 2'd1, "R8");
    check_status("R8");
    // R9 wait-for-interrupt with and without TW
    send(csr_i(3'b010, 5'd0, 5'd2, 12'h300), 32'h0020_0000, 2'd3, "R9");
    send(sys_i(12'h105), 32'h0, 2'd0, "R9");
    send(sys_i(12'h105), 32'h0, 2'd1, "R9");
    send(sys_i(12'h105), 32'h0, 2'd3, "R9");
    send(csr_i(3'b011, 5'd0, 5'd2, 12'h300), 32'h0020_0000, 2'd3, "R9");
    send(sys_i(12'h105), 32'h0, 2'd0, "R9");
    check_status("R9");
    // R11 malformed encodings
    send(32'h0020_80B3, 32'h0, 2'd3, "R11");
    send(csr_i(3'b100, 5'd1, 5'd1, 12'h340), 32'h0, 2'd3, "R11");
    send(sys_i(12'h7FF), 32'h0, 2'd3, "R11");
    send({12'h000, 5'd0, 3'd0, 5'd3, 7'b1110011}, 32'h0, 2'd3, "R11");
    drain();

    // R2 stalled consumer: record holds, input blocked
    bp_mode = 2;
    @(negedge clk);
    send(csr_i(3'b001, 5'd9, 5'd1, 12'h340), 32'hCAFE_0001, 2'd3, "R2");
    repeat (3) @(negedge clk);
    chk("R2", 32'(res_valid), 1, "res_valid held");
    chk("R2", 32'(in_ready), 0, "in_ready while held");
    chk("R2", res_rdata, sbq[0].rdata, "held rdata");
    bp_mode = 0;
    drain();

    // R2 random back-pressure with back-to-back writes
    bp_mode = 1;
    for (int i = 0; i < 40; i++)
      send(csr_i(3'b001, 5'(i % 31 + 1), 5'd1, 12'h340), 32'h1000_0000 + 32'(i), 2'd3, "R2");
    bp_mode = 0;
    drain();
    chk("R2", 32'(sbq.size()), 0, "scoreboard empty");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule